// File: doc/BRIEF.md
# USB Bus Idle Suspend Detector

This block watches the full-speed USB line state and decides when the function has to enter suspend and when it has to leave it. It also releases the function's core reset a fixed time after the bus supply is reported valid. It runs from a 6 MHz clock. D+, D- and the supply-valid level arrive asynchronously, and each passes through its own two-flop synchroniser before any decision is made.

Suspend begins only after the bus has stayed in the idle (J) state without a break for a programmable number of clocks. The default is 30000 clocks, about 5 ms. Any other line state, whether K, SE0 or the illegal SE1, restarts that window. While suspended, the first non-idle state brings the block back out. Leaving suspend clears the suspend flag and produces a single-clock wake pulse. The reset release timer holds `core_rst_n_o` low for 4200 counted clocks (about 700 us) once the supply is seen valid. While that reset is active, the suspend logic is held idle and its output is forced low.

Top module: `usb_idle_suspend`

## Requirements
- R1: While `rst_n_i` is sampled low at a rising clock edge, `core_rst_n_o`, `suspend_o` and `wake_o` are all low after that edge.
- R2: `core_rst_n_o` stays low while `vbus_valid_i` is low. Once `vbus_valid_i` is first sampled high and stays high, `core_rst_n_o` goes high on exactly the (RST_HOLD+2)-th rising edge: two synchroniser edges plus RST_HOLD counted clocks. RST_HOLD defaults to 4200.
- R3: If `vbus_valid_i` falls, `core_rst_n_o` and `suspend_o` are low after the third rising edge that samples it low. `suspend_o` is never high while `core_rst_n_o` is low. Losing the supply produces no wake pulse.
- R4: The idle state is J, with `dp_i`=1 and `dm_i`=0 (line code {dp,dm}=2'b10). K (2'b01), SE0 (2'b00) and SE1 (2'b11) are all non-idle. A change on the line takes effect two edges later, through the synchroniser.
- R5: With `core_rst_n_o` high, `suspend_o` rises on exactly the (IDLE_LIMIT+2)-th rising edge of an unbroken J run, counted from the first edge that samples J, and not earlier. IDLE_LIMIT defaults to 30000.
- R6: Any non-idle line state during the idle run clears the run, so the whole IDLE_LIMIT window starts again.
- R7: While suspended, a non-idle line state (K, SE0 or SE1) makes `suspend_o` fall on the third rising edge after it is first sampled.
- R8: `wake_o` is high for exactly one clock, starting at the same edge where `suspend_o` falls because of bus activity. It is never high otherwise.
- R9: Idle time seen while `core_rst_n_o` is low does not count. If the line is J throughout, `suspend_o` rises exactly IDLE_LIMIT edges after `core_rst_n_o` rises.
- R10: `suspend_o` stays high for as long as the line remains J.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 6 MHz block clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| vbus_valid_i | input | 1 | Asynchronous bus-supply-valid level from the comparator |
| dp_i | input | 1 | Asynchronous D+ receiver level |
| dm_i | input | 1 | Asynchronous D- receiver level |
| core_rst_n_o | output | 1 | Active-low reset for the function core, released after the hold time |
| suspend_o | output | 1 | High while the function is suspended |
| wake_o | output | 1 | One-clock pulse on leaving suspend due to bus activity |

## Verification
A stuck or miscounted idle counter shows up at the ports as `suspend_o` rising one or more edges away from the IDLE_LIMIT+2 boundary. A counter that fails to clear on K, SE0 or SE1 shows up as an early suspend after a blip. The bench probes both sides of that boundary. A wrong suspend state shows within three edges of a line change, either as a missing or doubled `wake_o` pulse or as `suspend_o` failing to fall. A fault in the reset release counter moves the `core_rst_n_o` rising edge away from RST_HOLD+2, and a supply drop that leaves `suspend_o` high is visible on the third edge.

// File: rtl/usbsus_pkg.sv
// Package: shared types for the USB bus idle suspend detector.
// Assumes line levels are already sampled into the block clock domain
// before the decode helper is applied.
package usbsus_pkg;

    // Full-speed line state, encoded as {D+, D-}.
    typedef enum logic [1:0] {
        LINE_SE0 = 2'b00,
        LINE_K   = 2'b01,
        LINE_J   = 2'b10,
        LINE_SE1 = 2'b11
    } line_state_e;

    // Suspend controller state.
    typedef enum logic {
        SUSP_ACTIVE    = 1'b0,
        SUSP_SUSPENDED = 1'b1
    } susp_state_e;

    // True only for the full-speed idle (J) state.
    function automatic logic line_is_idle(line_state_e ls);
        return (ls == LINE_J);
    endfunction

endpackage

// File: rtl/usbsus_sync.sv
// Module: usbsus_sync
// Multi-bit level synchroniser. Each bit goes through STAGES flops
// (at least two) and is treated independently. It assumes the inputs are
// slow levels, so bits may resolve on different cycles.
module usbsus_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the asynchronous levels through the flop chain.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/usbsus_line_decode.sv
// Module: usbsus_line_decode
// Turns the synchronised D+ and D- levels into a line state and an idle
// flag. Purely combinational. Assumes full-speed signalling, where idle is J.
module usbsus_line_decode
    import usbsus_pkg::*;
(
    input  logic dp_s_i,
    input  logic dm_s_i,
    output logic idle_o
);

    line_state_e line_state;

    // Classify the pair of levels and flag the idle state.
    always_comb begin
        line_state = line_state_e'({dp_s_i, dm_s_i});
        idle_o     = line_is_idle(line_state);
    end

endmodule

// File: rtl/usbsus_por_timer.sv
// Module: usbsus_por_timer
// Holds the core reset for HOLD clocks once the synchronised supply-valid
// level is high, then releases it. Losing the supply restarts the hold.
// Assumes HOLD >= 2.
module usbsus_por_timer #(
    parameter int HOLD = 4200
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic vbus_s_i,
    output logic release_o
);

    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [CW-1:0] hold_cnt_q;
    logic          release_q;

    // Count supply-valid clocks and release once the hold has elapsed.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || !vbus_s_i) begin
            hold_cnt_q <= '0;
            release_q  <= 1'b0;
        end else if (!release_q) begin
            if (hold_cnt_q == LAST) begin
                release_q <= 1'b1;
            end else begin
                hold_cnt_q <= hold_cnt_q + 1'b1;
            end
        end
    end

    assign release_o = release_q;

endmodule

// File: rtl/usbsus_idle_timer.sv
// Module: usbsus_idle_timer
// Counts consecutive idle clocks while the core is out of reset and
// raises expired_o once LIMIT idle clocks have been seen. Any non-idle
// clock, or core reset, clears the count. The count saturates, so
// expired_o stays high for the rest of the idle run. Assumes LIMIT >= 2.
module usbsus_idle_timer #(
    parameter int LIMIT = 30000
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic run_i,
    input  logic idle_i,
    output logic expired_o
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] idle_cnt_q;

    // Accumulate unbroken idle time, restarting on activity or reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || !run_i || !idle_i) begin
            idle_cnt_q <= '0;
        end else if (idle_cnt_q != TOP) begin
            idle_cnt_q <= idle_cnt_q + 1'b1;
        end
    end

    // Flag that the window is complete while the bus is still idle.
    always_comb begin
        expired_o = run_i && idle_i && (idle_cnt_q == TOP);
    end

endmodule

// File: rtl/usbsus_fsm.sv
// Module: usbsus_fsm
// Two-state suspend controller. It enters suspend when the idle timer
// expires and leaves on the first non-idle clock, producing a one-clock
// wake pulse. Core reset forces it to the active state with no pulse,
// and masks the suspend output at once.
module usbsus_fsm
    import usbsus_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic run_i,
    input  logic idle_i,
    input  logic expired_i,
    output logic suspend_o,
    output logic wake_o
);

    susp_state_e state_q;
    logic        wake_q;

    // Advance the suspend state and register the wake pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || !run_i) begin
            state_q <= SUSP_ACTIVE;
            wake_q  <= 1'b0;
        end else begin
            wake_q <= 1'b0;
            case (state_q)
                SUSP_ACTIVE: begin
                    if (expired_i) begin
                        state_q <= SUSP_SUSPENDED;
                    end
                end
                SUSP_SUSPENDED: begin
                    if (!idle_i) begin
                        state_q <= SUSP_ACTIVE;
                        wake_q  <= 1'b1;
                    end
                end
                default: state_q <= SUSP_ACTIVE;
            endcase
        end
    end

    // Mask the flag combinationally so it never outlives the core reset.
    always_comb begin
        suspend_o = (state_q == SUSP_SUSPENDED) && run_i;
        wake_o    = wake_q;
    end

endmodule

// File: rtl/usb_idle_suspend.sv
// Module: usb_idle_suspend
// Top level of the USB bus idle suspend detector. It synchronises D+, D-
// and supply-valid, times the core reset release, counts unbroken bus
// idle and drives the suspend flag and wake pulse. Assumes a 6 MHz clock;
// the defaults give about 700 us of reset hold and 5 ms of idle.
module usb_idle_suspend #(
    parameter int RST_HOLD    = 4200,
    parameter int IDLE_LIMIT  = 30000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic vbus_valid_i,
    input  logic dp_i,
    input  logic dm_i,
    output logic core_rst_n_o,
    output logic suspend_o,
    output logic wake_o
);

    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] raw_lvls;
    logic [SYNC_W-1:0] sync_lvls;
    logic              core_run;
    logic              bus_idle;
    logic              idle_expired;

    // Gather the asynchronous levels: {supply, D+, D-}.
    always_comb begin
        raw_lvls = {vbus_valid_i, dp_i, dm_i};
    end

    usbsus_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .async_i (raw_lvls),
        .sync_o  (sync_lvls)
    );

    usbsus_por_timer #(
        .HOLD (RST_HOLD)
    ) u_por (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .vbus_s_i  (sync_lvls[2]),
        .release_o (core_run)
    );

    usbsus_line_decode u_decode (
        .dp_s_i (sync_lvls[1]),
        .dm_s_i (sync_lvls[0]),
        .idle_o (bus_idle)
    );

    usbsus_idle_timer #(
        .LIMIT (IDLE_LIMIT)
    ) u_idle (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .run_i     (core_run),
        .idle_i    (bus_idle),
        .expired_o (idle_expired)
    );

    usbsus_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .run_i     (core_run),
        .idle_i    (bus_idle),
        .expired_i (idle_expired),
        .suspend_o (suspend_o),
        .wake_o    (wake_o)
    );

    assign core_rst_n_o = core_run;

endmodule

// File: rtl/usb_idle_suspend_chk.sv
// Module: usb_idle_suspend_chk
// Port-level checker bound to usb_idle_suspend. It relates the outputs to
// the raw line and supply inputs, two synchroniser edges back.
module usb_idle_suspend_chk (
    input logic clk_i,
    input logic rst_n_i,
    input logic vbus_valid_i,
    input logic dp_i,
    input logic dm_i,
    input logic core_rst_n_o,
    input logic suspend_o,
    input logic wake_o
);

    // R3: no suspend flag while the core is held in reset.
    assert_no_susp_in_reset_R3: assert property (@(posedge clk_i)
        disable iff (!rst_n_i)
        !core_rst_n_o |-> !suspend_o);

    // R8: the wake pulse lasts a single clock.
    assert_wake_single_R8: assert property (@(posedge clk_i)
        disable iff (!rst_n_i)
        wake_o |=> !wake_o);

    // R8: a wake pulse only accompanies a suspend exit.
    assert_wake_on_exit_R8: assert property (@(posedge clk_i)
        disable iff (!rst_n_i)
        wake_o |-> $fell(suspend_o));

    // R7: leaving suspend with the core running needs bus activity and yields a wake.
    assert_exit_by_activity_R7: assert property (@(posedge clk_i)
        disable iff (!rst_n_i)
        ($fell(suspend_o) && core_rst_n_o) |->
            (wake_o && !($past(dp_i, 2) && !$past(dm_i, 2))));

    // R5: suspend is only entered while the synchronised line is J.
    assert_enter_on_idle_R5: assert property (@(posedge clk_i)
        disable iff (!rst_n_i)
        $rose(suspend_o) |-> ($past(dp_i, 2) && !$past(dm_i, 2)));

    // R2: the core reset is released only with the supply sampled valid.
    assert_release_needs_vbus_R2: assert property (@(posedge clk_i)
        disable iff (!rst_n_i)
        $rose(core_rst_n_o) |-> $past(vbus_valid_i, 2));

endmodule

bind usb_idle_suspend usb_idle_suspend_chk u_chk (.*);

// File: tb/usb_idle_suspend_tb.sv
// Bench for usb_idle_suspend. Reduced hold and idle limits keep the run
// short. A table of line segments is walked first for the idle/suspend
// behaviour, bracketed by directed tests for reset, supply and timing edges.
module usb_idle_suspend_tb;

    localparam int HOLD  = 50;
    localparam int LIMIT = 200;

    logic clk = 1'b0;
    logic rst_n;
    logic vbus;
    logic dp;
    logic dm;
    logic core_rst_n;
    logic suspend;
    logic wake;

    int checks = 0;
    int errors = 0;
    int wake_seen = 0;

    always #10 clk = ~clk;

    usb_idle_suspend #(
        .RST_HOLD   (HOLD),
        .IDLE_LIMIT (LIMIT)
    ) u_dut (
        .clk_i        (clk),
        .rst_n_i      (rst_n),
        .vbus_valid_i (vbus),
        .dp_i         (dp),
        .dm_i         (dm),
        .core_rst_n_o (core_rst_n),
        .suspend_o    (suspend),
        .wake_o       (wake)
    );

    // Segment table: line code {dp,dm}, length in edges, expected suspend
    // at the end, expected number of wake samples within the segment.
    localparam int NSEG = 13;
    localparam logic [1:0] SEG_LINE [NSEG] = '{
        2'b10, // 0  R5 J run short of the window
        2'b00, // 1  R6 SE0 blip
        2'b10, // 2  R6 window restarted by SE0
        2'b01, // 3  R6 K blip
        2'b10, // 4  R5 one edge short of the boundary
        2'b10, // 5  R5 boundary edge reached
        2'b10, // 6  R10 long idle keeps suspend
        2'b01, // 7  R7 R8 K wakes
        2'b10, // 8  R5 suspend again
        2'b00, // 9  R7 SE0 wakes
        2'b10, // 10 R5 suspend again
        2'b11, // 11 R4 R7 SE1 wakes
        2'b01  // 12 R8 no further pulse
    };
    localparam int SEG_LEN [NSEG] = '{150, 1, 150, 1, 201, 1, 500, 3, 300, 3, 250, 3, 10};
    localparam logic SEG_SUSP [NSEG] = '{0, 0, 0, 0, 0, 1, 1, 0, 1, 0, 1, 0, 0};
    localparam int SEG_WAKE [NSEG] = '{0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 1, 0};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance n edges, sampling outputs 1 ns after each rising edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            if (wake) wake_seen++;
        end
    endtask

    task automatic drive_line(input logic [1:0] code);
        @(negedge clk);
        dp = code[1];
        dm = code[0];
    endtask

    initial begin
        rst_n = 1'b0;
        vbus  = 1'b0;
        dp    = 1'b0;
        dm    = 1'b0;

        // R1: reset state.
        step(4);
        check(core_rst_n == 1'b0, "R1 core reset in reset", core_rst_n, 0);
        check(suspend == 1'b0, "R1 suspend in reset", suspend, 0);
        check(wake == 1'b0, "R1 wake in reset", wake, 0);

        // R2 / R9: no supply, line idle: core stays held, nothing counts.
        @(negedge clk);
        rst_n = 1'b1;
        dp = 1'b1;
        dm = 1'b0;
        step(80);
        check(core_rst_n == 1'b0, "R2 held without supply", core_rst_n, 0);
        check(suspend == 1'b0, "R9 no suspend before release", suspend, 0);

        // R2: release timing.
        @(negedge clk);
        vbus = 1'b1;
        step(HOLD + 1);
        check(core_rst_n == 1'b0, "R2 still held one edge early", core_rst_n, 0);
        step(1);
        check(core_rst_n == 1'b1, "R2 released at HOLD+2", core_rst_n, 1);

        // R9: idle counting starts at release.
        wake_seen = 0;
        step(LIMIT - 1);
        check(suspend == 1'b0, "R9 no suspend one edge early", suspend, 0);
        step(1);
        check(suspend == 1'b1, "R9 suspend LIMIT edges after release", suspend, 1);

        // R3: supply loss.
        @(negedge clk);
        vbus = 1'b0;
        step(2);
        check(core_rst_n == 1'b1, "R3 core still up after two edges", core_rst_n, 1);
        check(suspend == 1'b1, "R3 suspend still up after two edges", suspend, 1);
        step(1);
        check(core_rst_n == 1'b0, "R3 core reset on third edge", core_rst_n, 0);
        check(suspend == 1'b0, "R3 suspend cleared with core reset", suspend, 0);
        step(5);
        check(wake_seen == 0, "R3 no wake from supply loss", wake_seen, 0);

        // Re-release with the bus active (K).
        drive_line(2'b01);
        vbus = 1'b1;
        step(HOLD + 7);
        check(core_rst_n == 1'b1, "R2 released again", core_rst_n, 1);
        check(suspend == 1'b0, "R4 K is not idle", suspend, 0);

        // Table walk: R4 R5 R6 R7 R8 R10.
        for (int s = 0; s < NSEG; s++) begin
            drive_line(SEG_LINE[s]);
            wake_seen = 0;
            step(SEG_LEN[s] - 1);
            @(posedge clk);
            #1;
            if (wake) wake_seen++;
            check(suspend == SEG_SUSP[s], $sformatf("R5/R6/R7 segment %0d suspend", s),
                  suspend, SEG_SUSP[s]);
            check(wake_seen == SEG_WAKE[s], $sformatf("R8 segment %0d wake count", s),
                  wake_seen, SEG_WAKE[s]);
        end

        // R10: suspend held through a long idle, then R1 reset while suspended.
        drive_line(2'b10);
        step(3 * LIMIT);
        check(suspend == 1'b1, "R10 suspend held on long idle", suspend, 1);
        @(negedge clk);
        rst_n = 1'b0;
        wake_seen = 0;
        step(1);
        check(suspend == 1'b0, "R1 reset clears suspend", suspend, 0);
        check(core_rst_n == 1'b0, "R1 reset drops core reset", core_rst_n, 0);
        check(wake_seen == 0, "R1 reset gives no wake", wake_seen, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule